// File: doc/BRIEF.md
# Extended Mode Register Programming Sequencer

This block sits on the controller side of a DDR2-style memory interface. It turns requests to change the memory's DLL state, output drive strength and a few passed-through option bits into load-mode commands to the extended mode register. It issues them only when the memory is quiet, and it spaces every command after a load-mode by a programmable mode-register-set delay. It keeps a shadow of the last value written. A request whose value equals the shadow produces no command.

When a write turns the DLL on from off, the sequencer follows it with a load-mode to the base mode register that has the DLL-reset bit set. It then holds READ grants until a fixed lock window has passed. Self-refresh entry marks the DLL off. Exit restarts the same lock window, because the memory resets its DLL on exit. A READ request that arrives while the DLL is off or still locking is held with a stall flag until it can be granted.

All commands come out of a single registered command port: NOP, load-mode with a register select and an address word, or a READ grant.

Top module: `emr_seq`

## Requirements
- R1: A synchronous active-high reset sets the command to NOP (`cmd_op`=0) and `busy` low, and marks the DLL off, so a pending `rd_req` shows `rd_stall`=1 and gets no grant.
- R2: A load-mode command (`cmd_op`=1) appears only after a clock edge at which `banks_idle`=1 and `burst_act`=0. While either condition fails, the request waits and is not lost.
- R3: If a load-mode occupies cycle c, no command other than NOP appears before cycle c+TMRD_CYC.
- R4: An extended-register write has `cmd_sel`=1. Its address word carries, from bit 0 upward: bit 0 = DLL disable (0 means the DLL is enabled), bit 1 = reduced drive strength (1 means about 60 percent drive), and bits 2 and up = `upd_misc` unchanged.
- R5: An extended write that takes the DLL from disabled to enabled is followed, once R2 and R3 allow, by a load-mode with `cmd_sel`=0 and address MR_BASE with bit 8 set (DLL reset). With the memory quiet, this comes exactly TMRD_CYC cycles after the extended write.
- R6: A READ grant (`cmd_op`=2) comes at least LOCK_CYC cycles after the DLL-reset load-mode. If a read is already waiting, it comes exactly LOCK_CYC cycles after.
- R7: While in self refresh (after `sr_enter`, before `sr_exit`), no READ is granted. If the DLL is enabled, the edge that samples `sr_exit` starts a new LOCK_CYC window, counted from the cycle after that edge.
- R8: A request equal to the shadow value issues no command. A change that leaves the DLL enabled issues one extended write and no DLL reset.
- R9: A READ request held while the DLL is off or locking shows `rd_stall`=1 and is granted once the DLL is locked. It is never dropped, including after the DLL is disabled and later enabled again.
- R10: `busy` is high from a load-mode cycle until TMRD_CYC cycles after the last load-mode of a sequence, and it stays high across the gap between an enabling write and its DLL reset.
- R11: In every cycle that is not a load-mode, `cmd_sel` and `cmd_addr` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_req | input | 1 | One-cycle pulse that captures a new register request |
| upd_dll_en | input | 1 | Requested DLL state, 1 = enabled |
| upd_drv_low | input | 1 | Requested reduced drive strength |
| upd_misc | input | ADDR_W-2 | Option bits passed through to address bits 2 and up |
| banks_idle | input | 1 | All banks precharged |
| burst_act | input | 1 | A data burst is in progress |
| sr_enter | input | 1 | Pulse: self refresh entered |
| sr_exit | input | 1 | Pulse: self refresh left |
| rd_req | input | 1 | Read request, held until granted |
| rd_stall | output | 1 | Read request waiting on the DLL |
| cmd_op | output | 2 | 0 NOP, 1 load-mode, 2 READ |
| cmd_sel | output | 2 | Register select: 0 base, 1 extended |
| cmd_addr | output | ADDR_W | Load-mode address word |
| busy | output | 1 | Load-mode sequence in progress |

## Verification
Four patterns are used. A first enable from reset checks the exact spacing between the extended write, the DLL reset and the first READ. A drive-only change, held back by a burst or by busy banks, shows that the command waits and that no DLL reset follows. A repeated identical request shows that the shadow suppresses the command. A self-refresh round trip, plus a disable followed by a re-enable with a read held throughout, shows that the lock window restarts from the right cycle and that the held read survives.

// File: rtl/emr_seq_pkg.sv
package emr_seq_pkg;
  typedef enum logic [1:0] {
    OP_NOP  = 2'd0,
    OP_LMR  = 2'd1,
    OP_READ = 2'd2
  } op_e;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_DLLRST = 1'b1
  } seq_st_e;

  localparam logic [1:0] SEL_BASE = 2'd0;
  localparam logic [1:0] SEL_EXT  = 2'd1;
  localparam int unsigned DLL_RST_BIT = 8;
endpackage

// File: rtl/emr_delay_cnt.sv
module emr_delay_cnt #(
  parameter int unsigned SPAN = 2,
  localparam int unsigned CW = $clog2(SPAN + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  output logic [CW-1:0] remain
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= CW'(SPAN);
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign remain = cnt;
endmodule

// File: rtl/emr_shadow.sv
module emr_shadow #(
  parameter int unsigned W = 14,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         upd_req,
  input  logic [W-1:0] upd_val,
  input  logic         take,
  output logic         pend_vld,
  output logic [W-1:0] pend_val,
  output logic [W-1:0] shadow,
  output logic         differs
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_vld <= 1'b0;
      pend_val <= '0;
      shadow   <= RST_VAL;
    end else begin
      if (take) begin
        shadow   <= pend_val;
        pend_vld <= 1'b0;
      end
      if (upd_req) begin
        pend_val <= upd_val;
        pend_vld <= 1'b1;
      end
    end
  end

  assign differs = (pend_val != shadow);
endmodule

// File: rtl/emr_seq.sv
module emr_seq
  import emr_seq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 14,
  parameter int unsigned TMRD_CYC = 2,
  parameter int unsigned LOCK_CYC = 200,
  parameter logic [ADDR_W-1:0] MR_BASE = ADDR_W'('h0042)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_req,
  input  logic              upd_dll_en,
  input  logic              upd_drv_low,
  input  logic [ADDR_W-3:0] upd_misc,
  input  logic              banks_idle,
  input  logic              burst_act,
  input  logic              sr_enter,
  input  logic              sr_exit,
  input  logic              rd_req,
  output logic              rd_stall,
  output logic [1:0]        cmd_op,
  output logic [1:0]        cmd_sel,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              busy
);
  localparam int unsigned MRD_W = $clog2(TMRD_CYC + 1);
  localparam int unsigned LCK_W = $clog2(LOCK_CYC + 1);
  localparam logic [ADDR_W-1:0] SHADOW_RST = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] RST_WORD   = MR_BASE | (ADDR_W'(1) << DLL_RST_BIT);

  logic [ADDR_W-1:0] req_word;
  logic              pend_vld, differs;
  logic [ADDR_W-1:0] pend_val, shadow;
  logic [MRD_W-1:0]  mrd_rem;
  logic [LCK_W-1:0]  lock_rem;

  seq_st_e           st;
  logic              dll_on, in_sr;
  op_e               op_q;
  logic [1:0]        sel_q;
  logic [ADDR_W-1:0] addr_q;

  logic lm_ok, rd_ok, try_emr, fire_emr, fire_rst, fire_rd;
  logic en_edge, sr_go_in, sr_go_out, relock;

  assign req_word = {upd_misc, upd_drv_low, ~upd_dll_en};

  emr_shadow #(.W(ADDR_W), .RST_VAL(SHADOW_RST)) u_shadow (
    .clk(clk), .rst(rst), .upd_req(upd_req), .upd_val(req_word),
    .take(try_emr), .pend_vld(pend_vld), .pend_val(pend_val),
    .shadow(shadow), .differs(differs)
  );

  emr_delay_cnt #(.SPAN(TMRD_CYC)) u_mrd (
    .clk(clk), .rst(rst), .load(fire_emr | fire_rst), .remain(mrd_rem)
  );

  emr_delay_cnt #(.SPAN(LOCK_CYC)) u_lock (
    .clk(clk), .rst(rst), .load(fire_rst | relock), .remain(lock_rem)
  );

  always_comb begin
    lm_ok     = (mrd_rem <= MRD_W'(1)) && banks_idle && !burst_act && !in_sr;
    rd_ok     = dll_on && (lock_rem <= LCK_W'(1)) && !in_sr;
    fire_rst  = (st == ST_DLLRST) && lm_ok;
    try_emr   = (st == ST_IDLE) && pend_vld && lm_ok;
    fire_emr  = try_emr && differs;
    en_edge   = shadow[0] && !pend_val[0];
    fire_rd   = (st == ST_IDLE) && !fire_emr && rd_req && rd_ok
                && (mrd_rem <= MRD_W'(1));
    sr_go_in  = sr_enter && !in_sr;
    sr_go_out = sr_exit && in_sr && !sr_enter;
    relock    = sr_go_out && (st == ST_IDLE) && !shadow[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      dll_on <= 1'b0;
      in_sr  <= 1'b0;
      op_q   <= OP_NOP;
      sel_q  <= '0;
      addr_q <= '0;
    end else begin
      op_q   <= OP_NOP;
      sel_q  <= '0;
      addr_q <= '0;
      if (fire_rst) begin
        op_q   <= OP_LMR;
        sel_q  <= SEL_BASE;
        addr_q <= RST_WORD;
        st     <= ST_IDLE;
        dll_on <= 1'b1;
      end else if (fire_emr) begin
        op_q   <= OP_LMR;
        sel_q  <= SEL_EXT;
        addr_q <= pend_val;
        if (en_edge) st <= ST_DLLRST;
        if (pend_val[0]) dll_on <= 1'b0;
      end else if (fire_rd) begin
        op_q <= OP_READ;
      end
      if (sr_go_in) begin
        in_sr  <= 1'b1;
        dll_on <= 1'b0;
      end else if (sr_go_out) begin
        in_sr <= 1'b0;
        if (relock) dll_on <= 1'b1;
      end
    end
  end

  assign cmd_op   = op_q;
  assign cmd_sel  = sel_q;
  assign cmd_addr = addr_q;
  assign busy     = (st != ST_IDLE) || (mrd_rem != '0);
  assign rd_stall = rd_req && !rd_ok;
endmodule

// File: rtl/emr_seq_chk.sv
module emr_seq_chk
  import emr_seq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 14,
  parameter int unsigned TMRD_CYC = 2,
  parameter int unsigned LOCK_CYC = 200
) (
  input logic              clk,
  input logic              rst,
  input logic              banks_idle,
  input logic              burst_act,
  input logic              sr_enter,
  input logic              sr_exit,
  input logic [1:0]        cmd_op,
  input logic [1:0]        cmd_sel,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              busy
);
  localparam int unsigned MW = $clog2(TMRD_CYC + 1);
  localparam int unsigned LW = $clog2(LOCK_CYC + 1);

  logic [MW-1:0] since_lm;
  logic [LW-1:0] lock_since;
  logic          dis_seen, need_rst, in_sr_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_lm   <= MW'(TMRD_CYC);
      lock_since <= '0;
      dis_seen   <= 1'b1;
      need_rst   <= 1'b0;
      in_sr_c    <= 1'b0;
    end else begin
      if (cmd_op == OP_LMR) since_lm <= MW'(1);
      else if (since_lm < MW'(TMRD_CYC)) since_lm <= since_lm + 1'b1;

      if (cmd_op == OP_LMR && cmd_sel == SEL_BASE) lock_since <= LW'(1);
      else if (sr_exit && in_sr_c) lock_since <= '0;
      else if (lock_since < LW'(LOCK_CYC)) lock_since <= lock_since + 1'b1;

      if (cmd_op == OP_LMR && cmd_sel == SEL_EXT) begin
        dis_seen <= cmd_addr[0];
        if (dis_seen && !cmd_addr[0]) need_rst <= 1'b1;
      end
      if (cmd_op == OP_LMR && cmd_sel == SEL_BASE) need_rst <= 1'b0;

      if (sr_enter && !in_sr_c) in_sr_c <= 1'b1;
      else if (sr_exit) in_sr_c <= 1'b0;
    end
  end

  p_quiet_before_lm_r2: assert property (@(posedge clk) disable iff (rst)
    (cmd_op == OP_LMR) |-> $past(banks_idle && !burst_act));

  p_mrd_gap_r3: assert property (@(posedge clk) disable iff (rst)
    (cmd_op != OP_NOP) |-> (since_lm >= MW'(TMRD_CYC)));

  p_no_read_before_reset_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd_op == OP_READ) |-> !need_rst);

  p_read_after_lock_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd_op == OP_READ) |-> (lock_since >= LW'(LOCK_CYC)));

  p_no_read_in_sr_r7: assert property (@(posedge clk) disable iff (rst)
    (cmd_op == OP_READ) |-> !$past(in_sr_c));

  p_busy_on_lm_r10: assert property (@(posedge clk) disable iff (rst)
    (cmd_op == OP_LMR) |-> busy);

  p_nop_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    (cmd_op != OP_LMR) |-> (cmd_sel == 2'd0 && cmd_addr == '0));
endmodule

bind emr_seq emr_seq_chk #(
  .ADDR_W(ADDR_W), .TMRD_CYC(TMRD_CYC), .LOCK_CYC(LOCK_CYC)
) u_chk (
  .clk(clk), .rst(rst), .banks_idle(banks_idle), .burst_act(burst_act),
  .sr_enter(sr_enter), .sr_exit(sr_exit), .cmd_op(cmd_op),
  .cmd_sel(cmd_sel), .cmd_addr(cmd_addr), .busy(busy)
);

// File: tb/tb_emr_seq.sv
module tb_emr_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW   = 14;
  localparam int TMRD = 3;
  localparam int LOCK = 200;
  localparam logic [AW-1:0] MRB = 14'h0042;
  localparam logic [AW-1:0] RSTW = MRB | 14'h0100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic upd_req = 0, upd_dll_en = 0, upd_drv_low = 0;
  logic [AW-3:0] upd_misc = '0;
  logic banks_idle = 1, burst_act = 0, sr_enter = 0, sr_exit = 0, rd_req = 0;
  logic rd_stall, busy;
  logic [1:0] cmd_op, cmd_sel;
  logic [AW-1:0] cmd_addr;

  int checks = 0, errors = 0;
  int lm_count = 0, rd_count = 0;
  bit wd_hit = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  emr_seq #(.ADDR_W(AW), .TMRD_CYC(TMRD), .LOCK_CYC(LOCK), .MR_BASE(MRB)) dut (
    .clk(clk), .rst(rst), .upd_req(upd_req), .upd_dll_en(upd_dll_en),
    .upd_drv_low(upd_drv_low), .upd_misc(upd_misc), .banks_idle(banks_idle),
    .burst_act(burst_act), .sr_enter(sr_enter), .sr_exit(sr_exit),
    .rd_req(rd_req), .rd_stall(rd_stall), .cmd_op(cmd_op), .cmd_sel(cmd_sel),
    .cmd_addr(cmd_addr), .busy(busy)
  );

  // Behavioural reference: time stamps of events instead of down-counters.
  int m_cyc, m_last_lm, m_lock_at;
  bit m_rst_due, m_dll, m_sr, m_pv, m_started = 0;
  logic [AW-1:0] m_shadow, m_pend, m_addr;
  int m_cmd, m_sel;
  bit t_gap, t_lm, t_lock, t_fired, t_due;
  logic [AW-1:0] t_sh;

  always @(posedge clk) begin
    if (rst) begin
      m_cyc = 0; m_last_lm = -1000; m_lock_at = -1000;
      m_rst_due = 0; m_dll = 0; m_sr = 0; m_pv = 0;
      m_shadow = 14'd1; m_pend = '0;
      m_cmd = 0; m_sel = 0; m_addr = '0;
    end else begin
      m_cyc = m_cyc + 1;
      t_gap  = (m_cyc - m_last_lm) >= TMRD;
      t_lm   = t_gap && banks_idle && !burst_act && !m_sr;
      t_lock = m_dll && !m_sr && ((m_cyc - m_lock_at) >= LOCK);
      t_due  = m_rst_due;
      t_sh   = m_shadow;
      t_fired = 0;
      m_cmd = 0; m_sel = 0; m_addr = '0;
      if (t_due) begin
        if (t_lm) begin
          m_cmd = 1; m_sel = 0; m_addr = RSTW;
          m_last_lm = m_cyc; m_lock_at = m_cyc; m_dll = 1; m_rst_due = 0;
          t_fired = 1;
        end
      end else if (m_pv && t_lm) begin
        m_pv = 0;
        if (m_pend != m_shadow) begin
          m_cmd = 1; m_sel = 1; m_addr = m_pend; m_last_lm = m_cyc;
          if (m_shadow[0] && !m_pend[0]) m_rst_due = 1;
          if (m_pend[0]) m_dll = 0;
          m_shadow = m_pend;
          t_fired = 1;
        end
      end
      if (!t_due && !t_fired && rd_req && t_lock && t_gap) m_cmd = 2;
      if (sr_enter && !m_sr) begin
        m_sr = 1; m_dll = 0;
      end else if (sr_exit && m_sr) begin
        m_sr = 0;
        if (!t_due && !t_sh[0]) begin
          m_dll = 1; m_lock_at = m_cyc;
        end
      end
      if (upd_req) begin
        m_pend = {upd_misc, upd_drv_low, ~upd_dll_en};
        m_pv = 1;
      end
    end
    m_started = 1;
  end

  // Per-cycle comparison (R3, R4, R10, R11 and the rest through the model).
  bit e_busy, e_stall;
  always @(negedge clk) begin
    #1;
    if (m_started && !wd_hit) begin
      e_busy  = m_rst_due || ((m_cyc - m_last_lm) < TMRD);
      e_stall = rd_req && !(m_dll && !m_sr && ((m_cyc + 1 - m_lock_at) >= LOCK));
      checks++;
      if (int'(cmd_op) != m_cmd || int'(cmd_sel) != m_sel || cmd_addr != m_addr
          || busy != e_busy || rd_stall != e_stall) begin
        errors++;
        $display("FAIL R3 R10 R11 model cycle %0d: op/sel/addr/busy/stall actual %0d/%0d/%h/%0b/%0b expected %0d/%0d/%h/%0b/%0b",
                 m_cyc, cmd_op, cmd_sel, cmd_addr, busy, rd_stall,
                 m_cmd, m_sel, m_addr, e_busy, e_stall);
      end
      if (cmd_op == 2'd1) lm_count++;
      if (cmd_op == 2'd2) rd_count++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic wait_op(input int op, input int lim, output int at);
    at = -1;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      #1;
      if (int'(cmd_op) == op) begin
        at = m_cyc;
        break;
      end
    end
    #1;
  endtask

  task automatic pulse_upd(input bit en, input bit drv, input logic [AW-3:0] misc);
    upd_dll_en = en; upd_drv_low = drv; upd_misc = misc; upd_req = 1;
    step(1);
    upd_req = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    wd_hit = 1;
    checks++; errors++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int t0, t1, t2, s, lmc, rdc;
    rd_req = 1;
    step(3);
    rst = 0;
    step(1);
    chk(cmd_op == 2'd0, "R1 op after reset", cmd_op, 0);
    chk(busy == 1'b0, "R1 busy after reset", busy, 0);
    chk(rd_stall == 1'b1, "R1 read stalled after reset", rd_stall, 1);

    // First enable from reset.
    pulse_upd(1, 0, '0);
    wait_op(1, 20, t0);
    chk(cmd_sel == 2'd1 && cmd_addr == 14'd0, "R4 enable write word", cmd_addr, 0);
    wait_op(1, 20, t1);
    chk(t1 - t0 == TMRD, "R5 reset spacing", t1 - t0, TMRD);
    chk(cmd_sel == 2'd0 && cmd_addr == RSTW, "R5 reset word", cmd_addr, RSTW);
    chk(rd_stall == 1'b1, "R9 stall while locking", rd_stall, 1);
    step(TMRD - 1);
    chk(busy == 1'b1, "R10 busy in last wait cycle", busy, 1);
    step(1);
    chk(busy == 1'b0, "R10 busy clear after wait", busy, 0);
    wait_op(2, 400, t2);
    chk(t2 - t1 == LOCK, "R6 lock window", t2 - t1, LOCK);
    rd_req = 0;
    step(5);

    // Drive-only change held by a burst.
    burst_act = 1;
    lmc = lm_count;
    pulse_upd(1, 1, '0);
    step(10);
    chk(lm_count == lmc, "R2 held during burst", lm_count - lmc, 0);
    burst_act = 0;
    wait_op(1, 20, t0);
    chk(cmd_sel == 2'd1 && cmd_addr == 14'd2, "R4 drive bit", cmd_addr, 2);
    lmc = lm_count;
    step(60);
    chk(lm_count == lmc, "R8 no reset on drive change", lm_count - lmc, 0);
    rd_req = 1;
    wait_op(2, 10, t2);
    chk(t2 != -1, "R9 read granted when locked", t2, 1);
    rd_req = 0;

    // Repeat of identical value.
    lmc = lm_count;
    pulse_upd(1, 1, '0);
    step(20);
    chk(lm_count == lmc, "R8 equal request silent", lm_count - lmc, 0);

    // Self refresh round trip.
    sr_enter = 1; step(1); sr_enter = 0;
    rd_req = 1;
    rdc = rd_count;
    step(30);
    chk(rd_count == rdc, "R7 no read in self refresh", rd_count - rdc, 0);
    chk(rd_stall == 1'b1, "R7 stall in self refresh", rd_stall, 1);
    s = m_cyc + 1;
    sr_exit = 1; step(1); sr_exit = 0;
    wait_op(2, 400, t2);
    chk(t2 - s == LOCK, "R7 relock window", t2 - s, LOCK);
    rd_req = 0;
    step(3);

    // Option bits, held by open banks.
    banks_idle = 0;
    lmc = lm_count;
    pulse_upd(1, 1, 12'd5);
    step(8);
    chk(lm_count == lmc, "R2 held while banks open", lm_count - lmc, 0);
    banks_idle = 1;
    wait_op(1, 20, t0);
    chk(cmd_sel == 2'd1 && cmd_addr == 14'd22, "R4 misc bits", cmd_addr, 22);

    // Disable, read held throughout, then enable again.
    pulse_upd(0, 1, 12'd5);
    wait_op(1, 20, t0);
    chk(cmd_addr == 14'd23, "R4 disable bit", cmd_addr, 23);
    rd_req = 1;
    rdc = rd_count;
    step(300);
    chk(rd_count == rdc, "R9 no read while disabled", rd_count - rdc, 0);
    chk(rd_stall == 1'b1, "R9 stall while disabled", rd_stall, 1);
    pulse_upd(1, 1, 12'd5);
    wait_op(1, 20, t0);
    chk(cmd_addr == 14'd22, "R5 re-enable word", cmd_addr, 22);
    wait_op(1, 20, t1);
    chk(cmd_sel == 2'd0 && t1 - t0 == TMRD, "R5 re-enable reset", t1 - t0, TMRD);
    wait_op(2, 400, t2);
    chk(t2 - t1 == LOCK, "R9 held read granted after relock", t2 - t1, LOCK);
    rd_req = 0;
    step(5);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule